// File: doc/BRIEF.md
# Eight-Input Expander I2C Slave Controller

This block is the bus-facing half of an eight-input port expander. It watches oversampled SCL and SDA lines on the system clock and finds START and STOP conditions. It takes in a 7-bit address and a direction bit, and it acknowledges only its own address. The slave drives SDA through a single active-high pull-down enable (`sda_oe`). The address is formed from a fixed three-bit prefix, 110 binary, followed by a 4-bit selector that arrives on an input port.

A read sends the port snapshot first and then the transition-flag byte. The two keep alternating, most significant bit first, until the master declines a byte. Each port byte is captured from `port_i` at the moment it is loaded. The first port byte is captured in the same cycle the slave begins its address acknowledge. A write acknowledges every data byte and copies each one into the interrupt-mask output, so the last byte before STOP is the value that stays. The neighbouring transition logic receives three single-cycle strobes: address acknowledged, flag byte sent and STOP seen.

An active-low bus-abort input returns the interface to idle and releases SDA at once. It leaves the mask untouched. The system reset additionally sets the mask to all ones.

Top module: `i2cx_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) only an address equal to {110b, dev_sel}. Any other address gets no ACK, and the bus is ignored until the next START: no drive, no mask change and no address strobe.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START in the middle of a byte restarts address reception.
- R3: During a write every data byte is acknowledged and loaded into `irq_mask`. After STOP the mask holds the last byte sent.
- R4: During a read the bytes alternate port data, flag data, port data and so on, each sent MSB first. After a master NACK the slave stops driving SDA.
- R5: `addr_ack_stb` pulses once per matched address, for both read and write. The first read byte is the value of `port_i` in the cycle of that strobe. Later port bytes are resampled when they are loaded.
- R6: `flag_sent_stb` pulses once for each flag byte completed, in the cycle SDA is released for the master's acknowledge.
- R7: `stop_stb` pulses once for each STOP condition, and SDA is released in that cycle.
- R8: While `bus_rst_n` is low the interface goes idle and SDA is released on the next clock. The mask keeps its value.
- R9: After system reset `sda_oe` is 0, `irq_mask` is 8'hFF and no strobe is active.
- R10: `sda_oe` changes only after a falling SCL edge. It never changes while SCL has been high for several system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low system reset |
| bus_rst_n | input | 1 | Active-low bus abort; mask kept |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_sel | input | 4 | Low four address bits |
| port_i | input | 8 | Current input-port levels |
| flags_i | input | 8 | Transition flags from the detection logic |
| irq_mask | output | 8 | Interrupt-mask register |
| addr_ack_stb | output | 1 | Matched-address acknowledge pulse |
| flag_sent_stb | output | 1 | Flag byte transmitted pulse |
| stop_stb | output | 1 | STOP condition pulse |

## Verification
The bench sends an address that differs from the slave's own only in its selector bits. A design that compared only the fixed prefix would acknowledge that address and then overwrite the mask with the stray data byte. A four-byte read changes `port_i` just after the address acknowledge and changes `flags_i` between bytes. This exposes a design that samples the port too late, never resamples it, or sends the flag byte where the port byte belongs. A repeated START in the middle of a byte, and a bus abort while the slave is pulling SDA low, show up as a lost acknowledge, a stuck-low SDA or a corrupted mask.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    parameter int DW    = 8;
    parameter int SEL_W = 4;
    parameter int ADR_W = 7;
    localparam int PFX_W = ADR_W - SEL_W;
    localparam int CNT_W = $clog2(DW);
    localparam logic [PFX_W-1:0] ADDR_PFX = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK, ST_RLOD
    } ctl_st_e;

    typedef struct packed {
        ctl_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    sh;
        logic [DW-1:0]    mask;
        logic             oe;
        logic             rw;
        logic             sel;     // 1: byte in shifter is the flag byte
        logic             ack_stb;
        logic             flag_stb;
        logic             stop_stb;
    } ctl_reg_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic qd_o
);
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb pipe_d = {pipe_q[STAGES-1:0], d_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q_o  = pipe_q[STAGES-1];
    assign qd_o = pipe_q[STAGES];
endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
    import i2cx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_n,
    input  logic             scl_lvl,
    input  logic             scl_prv,
    input  logic             sda_lvl,
    input  logic             sda_prv,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [DW-1:0]    port_i,
    input  logic [DW-1:0]    flags_i,
    output logic             sda_oe,
    output logic [DW-1:0]    irq_mask,
    output logic             addr_ack_stb,
    output logic             flag_sent_stb,
    output logic             stop_stb
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);
    localparam ctl_reg_t RST_VAL = '{st: ST_IDLE, cnt: '0, sh: '0, mask: '1,
                                     oe: 1'b0, rw: 1'b0, sel: 1'b0,
                                     ack_stb: 1'b0, flag_stb: 1'b0, stop_stb: 1'b0};

    ctl_reg_t r_d, r_q;
    logic scl_rise, scl_fall, start_c, stop_c;
    logic [DW-1:0] rx_byte, nxt_byte;

    always_comb begin
        scl_rise = scl_lvl & ~scl_prv;
        scl_fall = ~scl_lvl & scl_prv;
        start_c  = scl_lvl & scl_prv & sda_prv & ~sda_lvl;
        stop_c   = scl_lvl & scl_prv & ~sda_prv & sda_lvl;
        rx_byte  = {r_q.sh[DW-2:0], sda_lvl};
        nxt_byte = r_q.sel ? port_i : flags_i;

        r_d          = r_q;
        r_d.ack_stb  = 1'b0;
        r_d.flag_stb = 1'b0;
        r_d.stop_stb = 1'b0;

        if (!bus_rst_n) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (start_c) begin
            r_d.st  = ST_ADDR;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (stop_c) begin
            r_d.st       = ST_IDLE;
            r_d.oe       = 1'b0;
            r_d.stop_stb = 1'b1;
        end else begin
            unique case (r_q.st)
                ST_ADDR: if (scl_rise) begin
                    r_d.sh = rx_byte;
                    if (r_q.cnt == LAST) begin
                        r_d.rw = sda_lvl;
                        r_d.st = (r_q.sh[ADR_W-1:0] == {ADDR_PFX, dev_sel}) ? ST_AACK : ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_AACK: if (scl_fall) begin
                    if (!r_q.oe) begin
                        r_d.oe      = 1'b1;
                        r_d.ack_stb = 1'b1;
                        r_d.sh      = port_i;
                        r_d.sel     = 1'b0;
                    end else begin
                        r_d.cnt = '0;
                        r_d.st  = r_q.rw ? ST_RDAT : ST_WDAT;
                        r_d.oe  = r_q.rw ? ~r_q.sh[DW-1] : 1'b0;
                    end
                end
                ST_WDAT: if (scl_rise) begin
                    r_d.sh = rx_byte;
                    if (r_q.cnt == LAST) begin
                        r_d.mask = rx_byte;
                        r_d.st   = ST_WACK;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_WACK: if (scl_fall) begin
                    if (!r_q.oe) begin
                        r_d.oe = 1'b1;
                    end else begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        r_d.st  = ST_WDAT;
                    end
                end
                ST_RDAT: if (scl_fall) begin
                    if (r_q.cnt == LAST) begin
                        r_d.oe       = 1'b0;
                        r_d.st       = ST_RACK;
                        r_d.flag_stb = r_q.sel;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.sh  = {r_q.sh[DW-2:0], 1'b0};
                        r_d.oe  = ~r_q.sh[DW-2];
                    end
                end
                ST_RACK: if (scl_rise) begin
                    r_d.st = sda_lvl ? ST_IDLE : ST_RLOD;
                end
                ST_RLOD: if (scl_fall) begin
                    r_d.sel = ~r_q.sel;
                    r_d.sh  = nxt_byte;
                    r_d.oe  = ~nxt_byte[DW-1];
                    r_d.cnt = '0;
                    r_d.st  = ST_RDAT;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign sda_oe        = r_q.oe;
    assign irq_mask      = r_q.mask;
    assign addr_ack_stb  = r_q.ack_stb;
    assign flag_sent_stb = r_q.flag_stb;
    assign stop_stb      = r_q.stop_stb;
endmodule

// File: rtl/i2cx_slave.sv
module i2cx_slave
    import i2cx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] dev_sel,
    input  logic [DW-1:0]    port_i,
    input  logic [DW-1:0]    flags_i,
    output logic [DW-1:0]    irq_mask,
    output logic             addr_ack_stb,
    output logic             flag_sent_stb,
    output logic             stop_stb
);
    localparam int NLINES = 2;   // index 0: SCL, index 1: SDA

    logic [NLINES-1:0] raw, lvl, prv;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2cx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw[g]),
            .q_o  (lvl[g]),
            .qd_o (prv[g])
        );
    end

    i2cx_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_rst_n    (bus_rst_n),
        .scl_lvl      (lvl[0]),
        .scl_prv      (prv[0]),
        .sda_lvl      (lvl[1]),
        .sda_prv      (prv[1]),
        .dev_sel      (dev_sel),
        .port_i       (port_i),
        .flags_i      (flags_i),
        .sda_oe       (sda_oe),
        .irq_mask     (irq_mask),
        .addr_ack_stb (addr_ack_stb),
        .flag_sent_stb(flag_sent_stb),
        .stop_stb     (stop_stb)
    );
endmodule

// File: rtl/i2cx_slave_chk.sv
module i2cx_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [7:0] irq_mask,
    input logic       addr_ack_stb,
    input logic       flag_sent_stb,
    input logic       stop_stb
);
    p_oe_quiet_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
        |-> $stable(sda_oe));

    p_strobes_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_ack_stb, flag_sent_stb, stop_stb}));

    p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> !sda_oe);

    p_abort_keeps_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rst_n |=> $stable(irq_mask));

    p_stop_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> !sda_oe);

    p_flag_sent_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sent_stb |-> !sda_oe);

    p_addr_ack_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_ack_stb |-> sda_oe);
endmodule

bind i2cx_slave i2cx_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst_n    (bus_rst_n),
    .scl_i        (scl_i),
    .sda_oe       (sda_oe),
    .irq_mask     (irq_mask),
    .addr_ack_stb (addr_ack_stb),
    .flag_sent_stb(flag_sent_stb),
    .stop_stb     (stop_stb)
);

// File: tb/i2cx_slave_tb.sv
module i2cx_slave_tb;
    localparam int Q = 6;
    localparam logic [3:0] SEL = 4'h5;
    localparam logic [6:0] MY_ADR = {3'b110, SEL};

    logic clk = 1'b0;
    logic rst_n = 1'b0, bus_rst_n = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] port_i = 8'h00, flags_i = 8'h00;
    logic sda_oe, addr_ack_stb, flag_sent_stb, stop_stb;
    logic [7:0] irq_mask;
    wire sda_bus = sda_m & ~sda_oe;

    int checks = 0, fails = 0;
    int n_ack = 0, n_flag = 0, n_stop = 0;
    bit may_drive = 1'b0, done = 1'b0;
    int hi_run = 0;
    logic last_oe = 1'b0;

    always #4 clk = ~clk;

    i2cx_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .dev_sel(SEL), .port_i(port_i), .flags_i(flags_i),
        .irq_mask(irq_mask), .addr_ack_stb(addr_ack_stb), .flag_sent_stb(flag_sent_stb),
        .stop_stb(stop_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) begin
            n_ack  <= n_ack + int'(addr_ack_stb);
            n_flag <= n_flag + int'(flag_sent_stb);
            n_stop <= n_stop + int'(stop_stb);
        end
    end

    // per-clock reference comparison of the SDA drive (R10 / R1)
    always @(negedge clk) begin
        if (rst_n && bus_rst_n) begin
            hi_run = scl_m ? hi_run + 1 : 0;
            if (hi_run >= 5) chk(sda_oe == last_oe, "R10 oe stable while SCL high", sda_oe, last_oe);
            if (!may_drive) chk(!sda_oe, "R1 no drive outside slave slots", sda_oe, 0);
        end
        last_oe = sda_oe;
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    // send 8 bits; the slave may drive from the last bit's fall to the ACK's end
    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) may_drive = 1'b1;
            send_bit(v[i]);
        end
        recv_bit(ack);
        wq(Q);
        may_drive = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic nack);
        logic b;
        may_drive = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        if (nack) may_drive = 1'b0;
        send_bit(nack);
    endtask

    logic ack;
    logic [7:0] rd;
    int a0, f0, s0;

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R9 reset state
        chk(sda_oe == 1'b0, "R9 sda_oe after reset", sda_oe, 0);
        chk(irq_mask == 8'hFF, "R9 mask after reset", irq_mask, 8'hFF);
        chk(n_ack + n_flag + n_stop == 0, "R9 no strobes after reset", n_ack + n_flag + n_stop, 0);

        // R3 single write
        bus_start();
        send_byte({MY_ADR, 1'b0}, ack);
        chk(ack == 1'b0, "R1 own address acknowledged", ack, 0);
        send_byte(8'h3C, ack);
        chk(ack == 1'b0, "R3 data byte acknowledged", ack, 0);
        bus_stop();
        chk(irq_mask == 8'h3C, "R3 mask after write", irq_mask, 8'h3C);
        chk(n_ack == 1, "R5 one address strobe on write", n_ack, 1);
        chk(n_stop == 1, "R7 one stop strobe", n_stop, 1);

        // R3 multi-byte write: last byte stays
        bus_start();
        send_byte({MY_ADR, 1'b0}, ack);
        send_byte(8'hA5, ack);
        chk(irq_mask == 8'hA5, "R3 mask tracks each byte", irq_mask, 8'hA5);
        send_byte(8'h5A, ack);
        send_byte(8'h81, ack);
        chk(ack == 1'b0, "R3 third data byte acknowledged", ack, 0);
        bus_stop();
        chk(irq_mask == 8'h81, "R3 last byte remains", irq_mask, 8'h81);

        // R1 mismatching selector bits
        a0 = n_ack;
        bus_start();
        send_byte({3'b110, 4'h6, 1'b0}, ack);
        chk(ack == 1'b1, "R1 foreign address not acknowledged", ack, 1);
        send_byte(8'h00, ack);
        chk(ack == 1'b1, "R1 data after foreign address ignored", ack, 1);
        bus_stop();
        chk(irq_mask == 8'h81, "R1 mask untouched by foreign write", irq_mask, 8'h81);
        chk(n_ack == a0, "R1 no address strobe on mismatch", n_ack, a0);

        // R4/R5/R6 four-byte read
        port_i = 8'hC3; flags_i = 8'h96;
        f0 = n_flag;
        bus_start();
        send_byte({MY_ADR, 1'b1}, ack);
        chk(ack == 1'b0, "R1 read address acknowledged", ack, 0);
        port_i = 8'h11;
        read_byte(rd, 1'b0);
        chk(rd == 8'hC3, "R5 first byte sampled at address ACK", rd, 8'hC3);
        read_byte(rd, 1'b0);
        chk(rd == 8'h96, "R4 second byte is flags", rd, 8'h96);
        flags_i = 8'h42;
        read_byte(rd, 1'b0);
        chk(rd == 8'h11, "R4 third byte is resampled port", rd, 8'h11);
        read_byte(rd, 1'b1);
        chk(rd == 8'h42, "R4 fourth byte is flags", rd, 8'h42);
        wq(Q);
        chk(sda_oe == 1'b0, "R4 released after NACK", sda_oe, 0);
        chk(n_flag == f0 + 2, "R6 flag strobe per flag byte", n_flag, f0 + 2);
        bus_stop();

        // R2 repeated START mid-byte restarts address reception
        port_i = 8'h5E;
        a0 = n_ack;
        bus_start();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({MY_ADR, 1'b1}, ack);
        chk(ack == 1'b0, "R2 address after repeated START acknowledged", ack, 0);
        read_byte(rd, 1'b1);
        chk(rd == 8'h5E, "R2 read after repeated START", rd, 8'h5E);
        bus_stop();
        chk(n_ack == a0 + 1, "R2 one address strobe", n_ack, a0 + 1);

        // R8 abort while slave pulls SDA low
        port_i = 8'h00;
        s0 = n_stop;
        bus_start();
        send_byte({MY_ADR, 1'b1}, ack);
        may_drive = 1'b1;
        recv_bit(ack);
        bus_rst_n = 1'b0; wq(2); bus_rst_n = 1'b1;
        may_drive = 1'b0;
        wq(1);
        chk(sda_oe == 1'b0, "R8 SDA released by abort", sda_oe, 0);
        chk(irq_mask == 8'h81, "R8 mask kept through abort", irq_mask, 8'h81);
        for (int i = 0; i < 7; i++) recv_bit(ack);
        chk(ack == 1'b1, "R8 no drive after abort", ack, 1);
        send_bit(1'b1);
        bus_stop();
        chk(n_stop == s0 + 1, "R7 stop strobe after abort", n_stop, s0 + 1);

        // interface works after abort
        bus_start();
        send_byte({MY_ADR, 1'b0}, ack);
        send_byte(8'h0F, ack);
        bus_stop();
        chk(irq_mask == 8'h0F, "R3 write after abort", irq_mask, 8'h0F);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule